// File: doc/BRIEF.md
# Serial Command Line Assembler

This block sits on the receive side of a serial byte stream and turns keystrokes into a finished command line. Each accepted byte is sent straight back on an echo channel, so a terminal user sees what was typed. Printable bytes are written into a line buffer at a write pointer. A delete byte takes back the last entry and sets it to zero. Carriage returns and other control bytes are echoed but never stored.

A line-feed byte ends the line. The block then reports three values: the number of stored characters, the length of the first word (the action), and the offset at which the parameter string starts. While a line is pending, input is stalled. The consumer reads the buffer through a combinational read port. It then acknowledges the line, which clears the whole buffer to zeros and makes the block ready for the next command.

Top module: `cmd_line_asm`

## Requirements
- R1: A byte 0x0A ends the line: `line_valid` rises in the cycle after it is accepted, `line_len` equals the number of stored characters, and the 0x0A itself is not stored.
- R2: A byte 0x0D is echoed but never stored, and the write pointer does not move.
- R3: A byte 0x7F with at least one stored character moves the pointer back by one and sets the entry it leaves to 0x00; the next printable byte overwrites that entry.
- R4: Every accepted byte appears on `tx_data` with `tx_valid` high in the cycle after acceptance. It is held until `tx_ready` is seen, and `rx_ready` stays low for as long as the echo is pending.
- R5: When the line holds a 0x20 byte, `act_len` is the index of the first 0x20 and `param_ofs` is `act_len` plus one.
- R6: When the line holds no 0x20 byte, `act_len` and `param_ofs` both equal `line_len`, and the read port returns 0x00 at that offset. Any read address at or beyond the depth returns 0x00.
- R7: After `line_ack`, every buffer entry reads 0x00 and `line_valid` is low.
- R8: A byte 0x7F received with an empty buffer is ignored, and the pointer stays at zero.
- R9: Once DEPTH characters are stored, further printable bytes are dropped, but 0x0A is still accepted and reports `line_len` equal to DEPTH.
- R10: `line_valid` and its three results stay stable until `line_ack`, and `rx_ready` is low during that time.
- R11: Bytes below 0x20 other than 0x0A and 0x0D are echoed and dropped. Only 0x20 to 0x7E are stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block can accept a byte |
| tx_valid | output | 1 | Echo byte available |
| tx_data | output | 8 | Echo byte |
| tx_ready | input | 1 | Echo byte taken by the transmitter |
| line_valid | output | 1 | A complete line is pending |
| line_ack | input | 1 | Consumer has taken the line |
| line_len | output | $clog2(DEPTH+1) | Stored characters in the line |
| act_len | output | $clog2(DEPTH+1) | Length of the first word |
| param_ofs | output | $clog2(DEPTH+1) | Buffer index where the parameter starts |
| rd_addr | input | $clog2(DEPTH+1) | Buffer read address |
| rd_data | output | 8 | Buffer entry at `rd_addr`, combinational |

## Verification
The echo byte and every buffer change are due one clock after the edge that accepts a byte. The bench therefore drives each byte at a falling edge and checks the echo and the read port at the next falling edge. `line_valid` and its three results appear one edge after the accepted 0x0A, and the buffer is clear one edge after `line_ack`; both are sampled at the falling edge that follows. The read port is combinational, so the bench checks it a short delay after it changes `rd_addr`, inside the same low phase.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam logic [7:0] CH_LF  = 8'h0A;
    localparam logic [7:0] CH_CR  = 8'h0D;
    localparam logic [7:0] CH_DEL = 8'h7F;
    localparam logic [7:0] CH_SP  = 8'h20;
    localparam logic [7:0] CH_NUL = 8'h00;

    typedef enum logic [2:0] {
        BC_LINE_END,
        BC_RETURN,
        BC_ERASE,
        BC_STORE,
        BC_DROP
    } byte_cls_e;

    function automatic byte_cls_e classify(input logic [7:0] b);
        byte_cls_e c;
        if (b == CH_LF)                    c = BC_LINE_END;
        else if (b == CH_CR)               c = BC_RETURN;
        else if (b == CH_DEL)              c = BC_ERASE;
        else if (b >= CH_SP && b < CH_DEL) c = BC_STORE;
        else                               c = BC_DROP;
        return c;
    endfunction

endpackage

// File: rtl/cla_echo.sv
module cla_echo (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       busy
);

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } echo_st_t;

    echo_st_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (e_q.valid && tx_ready) begin
            e_d.valid = 1'b0;
        end
        if (load) begin
            e_d.valid = 1'b1;
            e_d.data  = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign tx_valid = e_q.valid;
    assign tx_data  = e_q.data;
    assign busy     = e_q.valid;

endmodule

// File: rtl/cla_tok_split.sv
module cla_tok_split #(
    parameter int DEPTH = 32,
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][7:0] mem,
    input  logic [PW-1:0]         fill,
    output logic [PW-1:0]         act_len,
    output logic [PW-1:0]         param_ofs
);

    import cla_pkg::*;

    logic [PW-1:0] first_sp;
    logic          found;

    always_comb begin
        first_sp = fill;
        found    = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (mem[i] == CH_SP && PW'(i) < fill) begin
                first_sp = PW'(i);
                found    = 1'b1;
            end
        end
    end

    assign act_len   = first_sp;
    assign param_ofs = found ? first_sp + PW'(1) : first_sp;

endmodule

// File: rtl/cmd_line_asm.sv
module cmd_line_asm #(
    parameter int DEPTH = 32,
    localparam int PW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    output logic          rx_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    input  logic          tx_ready,
    output logic          line_valid,
    input  logic          line_ack,
    output logic [PW-1:0] line_len,
    output logic [PW-1:0] act_len,
    output logic [PW-1:0] param_ofs,
    input  logic [PW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    import cla_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PW-1:0]         ptr;
        logic                  pend;
        logic [PW-1:0]         len;
        logic [PW-1:0]         act;
        logic [PW-1:0]         par;
    } line_st_t;

    line_st_t s_d, s_q;

    logic          echo_busy;
    logic          accept;
    logic [PW-1:0] tok_act;
    logic [PW-1:0] tok_par;
    logic [PW-1:0] ptr_m1;

    assign rx_ready = !s_q.pend && !echo_busy;
    assign accept   = rx_valid && rx_ready;
    assign ptr_m1   = s_q.ptr - PW'(1);

    cla_echo u_echo (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (rx_data),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .busy      (echo_busy)
    );

    cla_tok_split #(.DEPTH(DEPTH)) u_split (
        .mem       (s_q.mem),
        .fill      (s_q.ptr),
        .act_len   (tok_act),
        .param_ofs (tok_par)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.pend) begin
            if (line_ack) begin
                s_d.mem  = '0;
                s_d.ptr  = '0;
                s_d.pend = 1'b0;
            end
        end else if (accept) begin
            unique case (classify(rx_data))
                BC_LINE_END: begin
                    s_d.pend = 1'b1;
                    s_d.len  = s_q.ptr;
                    s_d.act  = tok_act;
                    s_d.par  = tok_par;
                end
                BC_ERASE: begin
                    if (s_q.ptr != '0) begin
                        s_d.mem[ptr_m1[IW-1:0]] = CH_NUL;
                        s_d.ptr                 = ptr_m1;
                    end
                end
                BC_STORE: begin
                    if (s_q.ptr < PW'(DEPTH)) begin
                        s_d.mem[s_q.ptr[IW-1:0]] = rx_data;
                        s_d.ptr                  = s_q.ptr + PW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_valid = s_q.pend;
    assign line_len   = s_q.len;
    assign act_len    = s_q.act;
    assign param_ofs  = s_q.par;
    assign rd_data    = (rd_addr < PW'(DEPTH)) ? s_q.mem[rd_addr[IW-1:0]] : CH_NUL;

endmodule

// File: rtl/cla_checker.sv
module cla_checker #(
    parameter int DEPTH = 32,
    localparam int PW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic [7:0]    rx_data,
    input logic          rx_ready,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          tx_ready,
    input logic          line_valid,
    input logic          line_ack,
    input logic [PW-1:0] line_len,
    input logic [PW-1:0] act_len,
    input logic [PW-1:0] param_ofs
);

    AST_LF_RAISES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && rx_data == 8'h0A |=> line_valid); // R1

    AST_ECHO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready |=> tx_valid && tx_data == $past(rx_data)); // R4

    AST_ECHO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R4

    AST_NO_RX_DURING_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready); // R4

    AST_TOKEN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> act_len <= line_len && param_ofs <= line_len && param_ofs >= act_len); // R5

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> line_len <= PW'(DEPTH)); // R9

    AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid && !line_ack |=> line_valid && $stable(line_len) && $stable(act_len) && $stable(param_ofs)); // R10

    AST_STALL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> !rx_ready); // R10

endmodule

bind cmd_line_asm cla_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .line_valid (line_valid),
    .line_ack   (line_ack),
    .line_len   (line_len),
    .act_len    (act_len),
    .param_ofs  (param_ofs)
);

// File: tb/test_cmd_line_asm.sv
`timescale 1ns/1ps
module test_cmd_line_asm;

    localparam int DEPTH = 8;
    localparam int PW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_ready;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          tx_ready = 1'b1;
    logic          line_valid;
    logic          line_ack = 1'b0;
    logic [PW-1:0] line_len;
    logic [PW-1:0] act_len;
    logic [PW-1:0] param_ofs;
    logic [PW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    cmd_line_asm #(.DEPTH(DEPTH)) i_cmd_line_asm (
        .clk, .rst_n, .rx_valid, .rx_data, .rx_ready, .tx_valid, .tx_data,
        .tx_ready, .line_valid, .line_ack, .line_len, .act_len, .param_ofs,
        .rd_addr, .rd_data
    );

    typedef struct packed {
        logic [63:0] s;
        logic [3:0]  n;
        logic [7:0]  len;
        logic [7:0]  act;
        logic [7:0]  par;
        logic [7:0]  pbyte;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{64'("use key"),               4'd7, 8'd7, 8'd3, 8'd4, "k"},
        '{64'("look"),                  4'd4, 8'd4, 8'd4, 8'd4, 8'h00},
        '{64'({"go", 8'h0d}),           4'd3, 8'd2, 8'd2, 8'd2, 8'h00},
        '{64'({"ab", 8'h7f, "c d"}),    4'd6, 8'd4, 8'd2, 8'd3, "d"},
        '{64'({8'h7f, "hi"}),           4'd3, 8'd2, 8'd2, 8'd2, 8'h00},
        '{64'(" x"),                    4'd2, 8'd2, 8'd0, 8'd1, "x"},
        '{64'({"a", 8'h01, "b"}),       4'd3, 8'd2, 8'd2, 8'd2, 8'h00},
        '{64'("get  map"),              4'd8, 8'd8, 8'd3, 8'd4, 8'h20}
    };

    task automatic chk(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, actual, actual, expected, expected);
        end
    endtask

    task automatic read_at(input int addr, input int expected, input string req);
        rd_addr = PW'(addr);
        #1;
        chk(rd_data == 8'(expected), req, rd_data, expected);
    endtask

    // Drive at a falling edge, check the echo at the next falling edge (R4)
    task automatic send_byte(input logic [7:0] b);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(tx_valid && tx_data == b, "R4 echo", tx_data, b);
    endtask

    task automatic ack_line();
        line_ack = 1'b1;
        @(negedge clk);
        line_ack = 1'b0;
        chk(!line_valid, "R7 line dropped after ack", line_valid, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk(rx_ready == 1'b1, "R4 reset rx_ready", rx_ready, 1);
        chk(tx_valid == 1'b0, "R4 reset tx_valid", tx_valid, 0);
        chk(line_valid == 1'b0, "R10 reset line_valid", line_valid, 0);
        read_at(0, 0, "R7 reset buffer");

        // Table of lines
        for (int v = 0; v < 8; v++) begin
            for (int i = 0; i < int'(VECS[v].n); i++) begin
                send_byte(VECS[v].s[8*(int'(VECS[v].n)-1-i) +: 8]);
            end
            send_byte(8'h0A);
            chk(line_valid, "R1 line_valid", line_valid, 1);
            chk(line_len == PW'(VECS[v].len), "R1 R2 R3 R8 R11 line_len", line_len, VECS[v].len);
            chk(act_len == PW'(VECS[v].act), "R5 R6 act_len", act_len, VECS[v].act);
            chk(param_ofs == PW'(VECS[v].par), "R5 R6 param_ofs", param_ofs, VECS[v].par);
            read_at(VECS[v].par, VECS[v].pbyte, "R5 R6 byte at param_ofs");
            @(negedge clk);
            chk(!rx_ready && line_valid, "R10 stall while pending", rx_ready, 0);
            ack_line();
            read_at(0, 0, "R7 entry 0 cleared");
            read_at(VECS[v].len - 1, 0, "R7 last entry cleared");
        end

        // R3: delete clears the entry and the pointer retreats
        send_byte("a");
        send_byte("b");
        send_byte(8'h7F);
        read_at(1, 0, "R3 erased entry");
        read_at(0, "a", "R3 earlier entry kept");
        send_byte("c");
        read_at(1, "c", "R3 overwrite after erase");
        send_byte(8'h0A);
        chk(line_len == PW'(2), "R3 line_len", line_len, 2);
        ack_line();

        // R8: delete on an empty buffer
        send_byte(8'h7F);
        send_byte("q");
        read_at(0, "q", "R8 pointer stayed at zero");
        send_byte(8'h0A);
        chk(line_len == PW'(1), "R8 line_len", line_len, 1);
        ack_line();

        // R9: overflow
        for (int i = 0; i < DEPTH + 3; i++) send_byte("z");
        read_at(DEPTH - 1, "z", "R9 last entry stored");
        send_byte(8'h0A);
        chk(line_valid, "R9 line feed accepted when full", line_valid, 1);
        chk(line_len == PW'(DEPTH), "R9 line_len", line_len, DEPTH);
        chk(param_ofs == PW'(DEPTH), "R6 param_ofs full", param_ofs, DEPTH);
        read_at(DEPTH, 0, "R6 read beyond depth");
        ack_line();

        // R4: echo held while the transmitter stalls
        @(negedge clk);
        tx_ready = 1'b0;
        send_byte("m");
        repeat (3) @(negedge clk);
        chk(tx_valid && tx_data == "m", "R4 echo held", tx_data, "m");
        chk(!rx_ready, "R4 rx stalled by echo", rx_ready, 0);
        tx_ready = 1'b1;
        @(negedge clk);
        chk(!tx_valid && rx_ready, "R4 echo released", tx_valid, 0);
        send_byte(8'h0A);
        ack_line();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule